// File: doc/BRIEF.md
# Serial CRC-16 Byte Engine with Seed Registers

This block computes a 16-bit cyclic redundancy check over a byte stream that software or a bus master feeds through a small write port. The running check value is one 16-bit state register, which is seen as an upper byte and a lower byte. The same two byte locations take the starting seed and return the result. The generator is x^16 + x^12 + x^5 + 1, which is 0x1021 once the implicit top term is dropped. No bits are reflected and no final XOR is applied.

A computation begins with a seed. The master writes the upper byte, which arms a seed sequence, and then writes the lower byte, which completes the seed. Once the seed is in place, every write to the lower byte is treated as message data. The engine shifts that byte into the state one bit per clock, most significant bit first, so a byte takes eight cycles. Writing a new seed starts a fresh computation at any time. No separate clear is needed.

The write side is a valid/ready channel. `wr_ready` is low for the whole time a byte is being shifted. A write is taken only on a clock edge where both `wr_valid` and `wr_ready` are high. A master that keeps `wr_valid` high while ready is low has its write taken on the first edge after ready returns. A write that is withdrawn before ready returns is never taken and has no effect. Reads are combinational from the current state, so a read made during shifting returns the partly updated value.

Top module: `crc16_engine`

## Requirements
- R1: After reset the state reads 0x0000 in both byte locations, `busy` is 0, `wr_ready` is 1, and seed mode is off.
- R2: A taken write with `wr_sel`=1 (upper byte) loads state[15:8] from `wr_data` and turns seed mode on. The state shows the new value on the next cycle.
- R3: A taken write with `wr_sel`=0 (lower byte) while seed mode is on loads state[7:0], turns seed mode off, and starts no shifting (`busy` stays 0).
- R4: A taken write with `wr_sel`=0 while seed mode is off starts shifting of `wr_data`. `busy` is high for exactly 8 cycles, starting the cycle after the write is taken.
- R5: Each shift cycle takes the next data bit, most significant first, and sets feedback = state[15] XOR that bit. The state then shifts left by one with a 0 entering bit 0, and is XORed with 0x1021 when the feedback is 1.
- R6: With seed 0xFFFF, the bytes of the ASCII text "123456789" give 0x29B1. With seed 0x0000 they give 0x31C3. Seed 0x102D and other seeds give the value that R5 predicts.
- R7: While `busy` is 1, `wr_ready` is 0. A write presented then and withdrawn before ready returns changes neither the state nor seed mode.
- R8: `rd_data` shows state[15:8] when `rd_sel`=1 and state[7:0] when `rd_sel`=0, combinationally, including partly updated values during shifting.
- R9: A new seed sequence written after a finished computation replaces the state, and the next data bytes continue from that seed.
- R10: When neither a write is taken nor shifting is active, the state holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Engine can take a write (low while shifting) |
| wr_sel | input | 1 | Target byte: 1 = upper, 0 = lower |
| wr_data | input | 8 | Write data byte |
| rd_sel | input | 1 | Read byte select: 1 = upper, 0 = lower |
| rd_data | output | 8 | Selected byte of the current state |
| busy | output | 1 | A byte is being shifted |

## Verification
Two functions can meet in one cycle: a new write arriving while the last shift cycle of the previous byte is still running. The bench provokes this by presenting one-cycle write pulses, to both byte locations, in the middle of a shift. It then judges the outcome from the final state and from whether seed mode was silently armed. The way it tells is the response to a following lower-byte write: that write must start shifting and not load a seed. It also samples the state one cycle into a shift to confirm that reads during the busy period show the partly updated value.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  localparam int CRC_W  = 16;
  localparam int BYTE_W = 8;
  localparam logic [CRC_W-1:0] CCITT_POLY = 16'h1021;

  typedef enum logic {
    SEL_LOW  = 1'b0,
    SEL_HIGH = 1'b1
  } byte_sel_e;
endpackage

// File: rtl/crc16_regif.sv
module crc16_regif (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_valid,
  input  logic wr_sel,
  input  logic busy,
  output logic wr_ready,
  output logic ld_high,
  output logic ld_low,
  output logic start,
  output logic seed_armed
);
  import crc16_pkg::*;

  logic taken;

  assign wr_ready = !busy;
  assign taken    = wr_valid && wr_ready;
  assign ld_high  = taken && (wr_sel == SEL_HIGH);
  assign ld_low   = taken && (wr_sel == SEL_LOW) && seed_armed;
  assign start    = taken && (wr_sel == SEL_LOW) && !seed_armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seed_armed <= 1'b0;
    else if (ld_high) seed_armed <= 1'b1;
    else if (ld_low)  seed_armed <= 1'b0;
  end
endmodule

// File: rtl/crc16_shift.sv
module crc16_shift #(
  parameter int CRC_W  = crc16_pkg::CRC_W,
  parameter int BYTE_W = crc16_pkg::BYTE_W,
  parameter logic [CRC_W-1:0] POLY = crc16_pkg::CCITT_POLY
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_high,
  input  logic              ld_low,
  input  logic              start,
  input  logic [BYTE_W-1:0] din,
  output logic [CRC_W-1:0]  crc,
  output logic              busy
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;
  logic              fb;
  logic [CRC_W-1:0]  nxt;

  assign fb = crc[CRC_W-1] ^ shreg[BYTE_W-1];

  for (genvar i = 0; i < CRC_W; i++) begin : g_tap
    if (i == 0) begin : g_lsb
      assign nxt[i] = fb & POLY[i];
    end else begin : g_mid
      assign nxt[i] = crc[i-1] ^ (fb & POLY[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc     <= '0;
      shreg   <= '0;
      bit_cnt <= '0;
      busy    <= 1'b0;
    end else if (busy) begin
      crc     <= nxt;
      shreg   <= {shreg[BYTE_W-2:0], 1'b0};
      bit_cnt <= bit_cnt + 1'b1;
      if (bit_cnt == LAST) busy <= 1'b0;
    end else if (start) begin
      shreg   <= din;
      bit_cnt <= '0;
      busy    <= 1'b1;
    end else if (ld_high) begin
      crc[CRC_W-1:CRC_W-BYTE_W] <= din;
    end else if (ld_low) begin
      crc[BYTE_W-1:0] <= din;
    end
  end
endmodule

// File: rtl/crc16_readmux.sv
module crc16_readmux #(
  parameter int CRC_W  = crc16_pkg::CRC_W,
  parameter int BYTE_W = crc16_pkg::BYTE_W
) (
  input  logic              rd_sel,
  input  logic [CRC_W-1:0]  crc,
  output logic [BYTE_W-1:0] rd_data
);
  import crc16_pkg::*;

  always_comb begin
    if (rd_sel == SEL_HIGH) rd_data = crc[CRC_W-1:CRC_W-BYTE_W];
    else                    rd_data = crc[BYTE_W-1:0];
  end
endmodule

// File: rtl/crc16_engine.sv
module crc16_engine #(
  parameter int CRC_W  = crc16_pkg::CRC_W,
  parameter int BYTE_W = crc16_pkg::BYTE_W,
  parameter logic [CRC_W-1:0] POLY = crc16_pkg::CCITT_POLY
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic              wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [BYTE_W-1:0] rd_data,
  output logic              busy
);
  logic             ld_high, ld_low, start, seed_armed;
  logic [CRC_W-1:0] crc_q;

  crc16_regif u_regif (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_sel(wr_sel),
    .busy(busy), .wr_ready(wr_ready), .ld_high(ld_high), .ld_low(ld_low),
    .start(start), .seed_armed(seed_armed)
  );

  crc16_shift #(.CRC_W(CRC_W), .BYTE_W(BYTE_W), .POLY(POLY)) u_shift (
    .clk(clk), .rst_n(rst_n), .ld_high(ld_high), .ld_low(ld_low),
    .start(start), .din(wr_data), .crc(crc_q), .busy(busy)
  );

  crc16_readmux #(.CRC_W(CRC_W), .BYTE_W(BYTE_W)) u_rd (
    .rd_sel(rd_sel), .crc(crc_q), .rd_data(rd_data)
  );
endmodule

// File: rtl/crc16_engine_checker.sv
module crc16_engine_checker #(
  parameter int CRC_W  = 16,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              wr_sel,
  input logic [BYTE_W-1:0] wr_data,
  input logic              busy,
  input logic [CRC_W-1:0]  crc,
  input logic              armed
);
  logic       taken;
  logic [7:0] run;

  assign taken = wr_valid && wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run <= '0;
    else if (busy) run <= run + 1'b1;
    else           run <= '0;
  end

  AST_HIGH_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    taken && wr_sel |=> (crc[CRC_W-1:CRC_W-BYTE_W] == $past(wr_data)) && armed); // R2

  AST_LOW_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    taken && !wr_sel && armed |=> (crc[BYTE_W-1:0] == $past(wr_data)) && !busy && !armed); // R3

  AST_DATA_START: assert property (@(posedge clk) disable iff (!rst_n)
    taken && !wr_sel && !armed |=> busy); // R4

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run == 8'(BYTE_W)); // R4

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run < 8'(BYTE_W)); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !taken |=> $stable(crc)); // R10
endmodule

bind crc16_engine crc16_engine_checker #(.CRC_W(CRC_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_sel(wr_sel), .wr_data(wr_data), .busy(busy), .crc(crc_q),
  .armed(seed_armed)
);

// File: tb/crc16_engine_test.sv
`timescale 1ns/1ps
module crc16_engine_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_sel = 1'b0;
  logic [7:0] rd_data;
  logic       busy;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  crc16_engine uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .busy(busy)
  );

  // seed, data byte
  localparam logic [23:0] VEC [0:7] = '{
    {16'hFFFF, 8'h00}, {16'h0000, 8'h80}, {16'h102D, 8'h31},
    {16'h8000, 8'h00}, {16'h0000, 8'h01}, {16'hFFFF, 8'hFF},
    {16'h1234, 8'hA5}, {16'hA5A5, 8'h5A}};

  function automatic logic [15:0] m_bit(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[15] ^ b;
    c = {c[14:0], 1'b0};
    if (fb) c = c ^ 16'h1021;
    return c;
  endfunction

  function automatic logic [15:0] m_byte(input logic [15:0] c, input logic [7:0] b);
    for (int i = 7; i >= 0; i--) c = m_bit(c, b[i]);
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd16(output logic [15:0] v);
    rd_sel = 1'b1; #1 v[15:8] = rd_data;
    rd_sel = 1'b0; #1 v[7:0] = rd_data;
  endtask

  task automatic seed(input logic [15:0] s);
    wr(1'b1, s[15:8]);
    wr(1'b0, s[7:0]);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v, m;
    string msg;
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd16(v);
    check("R1 state", v, 16'h0000);
    check("R1 busy", busy, 1'b0);
    check("R1 ready", wr_ready, 1'b1);
    rst_n = 1'b1;
    // R1 seed mode off: lower write starts shifting
    wr(1'b0, 8'h00);
    check("R1 seed mode off", busy, 1'b1);
    wait_idle();

    // table walk: R2 R3 R4 R5
    for (int k = 0; k < 8; k++) begin
      wr(1'b1, VEC[k][23:16]);
      rd_sel = 1'b1; #1;
      $sformat(msg, "R2 vec%0d", k);
      check(msg, rd_data, VEC[k][23:16]);
      wr(1'b0, VEC[k][15:8]);
      rd16(v);
      $sformat(msg, "R3 vec%0d", k);
      check(msg, {busy, v}, {1'b0, VEC[k][23:8]});
      wr(1'b0, VEC[k][7:0]);
      n = 0;
      while (busy) begin n++; @(negedge clk); end
      $sformat(msg, "R4 vec%0d", k);
      check(msg, n, 8);
      rd16(v);
      $sformat(msg, "R5 vec%0d", k);
      check(msg, v, m_byte(VEC[k][23:8], VEC[k][7:0]));
    end

    // R6 standard check strings
    seed(16'hFFFF);
    for (int i = 0; i < 9; i++) begin wr(1'b0, 8'h31 + 8'(i)); wait_idle(); end
    rd16(v);
    check("R6 seed FFFF", v, 16'h29B1);
    seed(16'h0000);
    for (int i = 0; i < 9; i++) begin wr(1'b0, 8'h31 + 8'(i)); wait_idle(); end
    rd16(v);
    check("R6 seed 0000", v, 16'h31C3);
    seed(16'h102D);
    m = 16'h102D;
    for (int i = 0; i < 9; i++) begin
      wr(1'b0, 8'h31 + 8'(i)); wait_idle();
      m = m_byte(m, 8'h31 + 8'(i));
    end
    rd16(v);
    check("R6 seed 102D", v, m);

    // R8 partial value one cycle into shifting
    seed(16'hFFFF);
    wr(1'b0, 8'h31);
    @(negedge clk);
    rd16(v);
    check("R8 partial", v, m_bit(16'hFFFF, 1'b0));
    wait_idle();

    // R7 writes while busy are ignored
    seed(16'h1234);
    wr(1'b0, 8'hA5);
    check("R7 ready low", wr_ready, 1'b0);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'hFF);
    wait_idle();
    rd16(v);
    check("R7 state", v, m_byte(16'h1234, 8'hA5));
    wr(1'b0, 8'h3C);
    check("R7 seed mode untouched", busy, 1'b1);
    wait_idle();
    rd16(v);
    check("R7 continue", v, m_byte(m_byte(16'h1234, 8'hA5), 8'h3C));

    // R9 reseed after a finished run
    seed(16'hBEEF);
    rd16(v);
    check("R9 reseed", v, 16'hBEEF);
    wr(1'b0, 8'h42); wait_idle();
    rd16(v);
    check("R9 continue", v, m_byte(16'hBEEF, 8'h42));

    // R10 idle hold
    repeat (5) @(negedge clk);
    rd16(v);
    check("R10 hold", v, m_byte(16'hBEEF, 8'h42));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule